// File: doc/BRIEF.md
# Machine/User Privilege Trap and Return Controller

This block holds the privilege state of a small two-level processor core (machine and user) and decides, one instruction at a time, whether that instruction proceeds, traps, returns from a trap or waits for an interrupt. The decode stage supplies one-hot flags for return-from-trap, wait-for-interrupt, environment call, breakpoint and illegal encodings. A CSR access travels with the same instruction on a small port that can read, overwrite, set bits or clear bits. The block owns the current privilege, the status word, the exception PC, the cause and the trap vector base. It answers in the same cycle with a redirect request, the redirect target and a stall flag.

Privilege rules apply to two instructions. A return-from-trap issued in user mode is refused as an illegal instruction. A wait-for-interrupt issued in user mode is refused only when the status word's timeout-wait bit is set. The wait logic is a two-state machine. In RUN, an accepted wait with no wake condition takes the transition "sleep entry" into SLEEP and raises the stall in the same cycle. In SLEEP, the stall holds and instruction inputs are ignored until the transition "wake" returns the machine to RUN. The wake condition is any interrupt that is both pending and enabled. The global interrupt enable plays no part in it.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the privilege is machine (priv_mode 3), the status word, exception PC and cause read 0, the trap vector reads RESET_VEC (default 0x100), and redirect and wfi_stall are low.
- R2: A return-from-trap in user mode does not return. It traps with cause 2, and afterwards the previous-privilege field (status bits 12:11) reads 0.
- R3: Taking any trap sets the previous-privilege field to the privilege the trap came from (0 from user, 3 from machine), copies MIE (bit 3) into MPIE (bit 7), clears MIE, enters machine mode, and redirects in the same cycle to the trap vector with its low two bits forced to 0.
- R4: After a trap, the exception PC holds the address of the trapping instruction with bit 0 cleared.
- R5: The timeout-wait bit is status bit 21. It is writable, and with only it set the status word reads 0x00200000.
- R6: Wait-for-interrupt in user mode completes without a trap when the timeout-wait bit is 0, and traps with cause 2 when it is 1. In machine mode it never traps.
- R7: An accepted wait with no pending-and-enabled interrupt raises wfi_stall in the same cycle and holds it until such an interrupt appears, whatever MIE is. While sleeping, instruction inputs have no effect and redirect stays low.
- R8: A return-from-trap in machine mode redirects to the exception PC. Its privilege becomes the previous-privilege field, MIE takes MPIE, MPIE becomes 1 and the previous-privilege field becomes 0.
- R9: A breakpoint traps with cause 3. An environment call traps with cause 8 from user mode and cause 11 from machine mode.
- R10: CSR operations are encoded as 0 read, 1 overwrite, 2 set bits, 3 clear bits. Addresses are 0x300 status, 0x305 trap vector, 0x341 exception PC and 0x342 cause. csr_rdata shows the value from before the operation. In the status word only bits 3, 7, 12:11 and 21 are stored, and others read 0. A previous-privilege value of 1 or 2 is not stored (the old value stays). The trap vector reads with bits 1:0 at 0.
- R11: In user mode, a CSR access to an address whose bits 9:8 are 3 traps with cause 2 and writes nothing. An access to another address does not trap.
- R12: Trap causes take priority in the order illegal (cause 2), then breakpoint, then environment call. A cycle that takes a trap performs no CSR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_pc | input | XLEN | Address of the presented instruction |
| is_mret | input | 1 | Return-from-trap instruction |
| is_wfi | input | 1 | Wait-for-interrupt instruction |
| is_ecall | input | 1 | Environment call |
| is_ebreak | input | 1 | Breakpoint |
| is_illegal | input | 1 | Decoder found an illegal encoding |
| csr_en | input | 1 | The instruction accesses a CSR |
| csr_op | input | 2 | 0 read, 1 overwrite, 2 set, 3 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Operand for the CSR operation |
| csr_rdata | output | XLEN | Value of the addressed CSR before the operation |
| irq_pending | input | IRQW | Pending interrupt lines |
| irq_enable | input | IRQW | Per-line interrupt enables |
| redirect | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | XLEN | Trap vector or exception PC |
| wfi_stall | output | 1 | Hold the pipeline while waiting |
| priv_mode | output | 2 | Current privilege, 0 user or 3 machine |

## Verification
Two functions can fall in the same cycle: a trap, and a CSR write carried by the same instruction. The bench provokes this by presenting an environment call with an overwrite of the trap vector. It judges the result by redirect_pc and by a later readback of the trap vector, which must still show the old base. A second overlap is an illegal flag together with a breakpoint, where the cause read back afterwards must be 2. The sleep path is provoked by offering an environment call while the block sleeps, and that call must produce no redirect.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        CSROP_READ  = 2'd0,
        CSROP_WRITE = 2'd1,
        CSROP_SET   = 2'd2,
        CSROP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } wait_state_e;

    localparam logic [11:0] ADDR_STATUS = 12'h300;
    localparam logic [11:0] ADDR_TVEC   = 12'h305;
    localparam logic [11:0] ADDR_EPC    = 12'h341;
    localparam logic [11:0] ADDR_CAUSE  = 12'h342;

    localparam int BIT_MIE  = 3;
    localparam int BIT_MPIE = 7;
    localparam int BIT_MPP  = 11;
    localparam int BIT_TW   = 21;

    localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
    localparam logic [4:0] CAUSE_BREAK   = 5'd3;
    localparam logic [4:0] CAUSE_ECALL_U = 5'd8;
    localparam logic [4:0] CAUSE_ECALL_M = 5'd11;

endpackage

// File: rtl/priv_trap_decide.sv
module priv_trap_decide
    import priv_trap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic        sleeping,
    input  priv_e       priv,
    input  logic        tw,
    input  logic        is_mret,
    input  logic        is_wfi,
    input  logic        is_ecall,
    input  logic        is_ebreak,
    input  logic        is_illegal,
    input  logic        csr_en,
    input  logic [1:0]  csr_op,
    input  logic [11:0] csr_addr,
    output logic        take_trap,
    output logic [4:0]  cause,
    output logic        do_mret,
    output logic        wfi_go,
    output logic        csr_we
);

    logic active;
    logic csr_fault;
    logic illegal_any;

    always_comb begin
        active      = instr_valid && !sleeping;
        csr_fault   = csr_en && (priv == PRIV_U) && (csr_addr[9:8] == 2'b11);
        illegal_any = is_illegal
                   || (is_mret && priv == PRIV_U)
                   || (is_wfi && priv == PRIV_U && tw)
                   || csr_fault;

        cause = 5'd0;
        if (illegal_any)    cause = CAUSE_ILLEGAL;
        else if (is_ebreak) cause = CAUSE_BREAK;
        else if (is_ecall)  cause = (priv == PRIV_U) ? CAUSE_ECALL_U : CAUSE_ECALL_M;

        take_trap = active && (illegal_any || is_ebreak || is_ecall);
        do_mret   = active && is_mret && !take_trap;
        wfi_go    = active && is_wfi && !take_trap;
        csr_we    = active && csr_en && (csr_op != CSROP_READ) && !take_trap;
    end

    // R2
    umode_mret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !sleeping && is_mret && priv == PRIV_U)
        |-> (take_trap && cause == CAUSE_ILLEGAL && !do_mret));

    // R6
    mmode_wfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !sleeping && is_wfi && priv == PRIV_M && !is_illegal
         && !is_ecall && !is_ebreak && !csr_en)
        |-> (!take_trap && wfi_go));

    // R12
    trap_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> !csr_we);

endmodule

// File: rtl/priv_wait_fsm.sv
module priv_wait_fsm
    import priv_trap_pkg::*;
#(
    parameter int IRQW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wfi_go,
    input  logic [IRQW-1:0] irq_pending,
    input  logic [IRQW-1:0] irq_enable,
    output logic            sleeping,
    output logic            wfi_stall
);

    wait_state_e state_q, state_d;
    logic        wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        wake      = |(irq_pending & irq_enable);
        state_d   = state_q;
        wfi_stall = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (wfi_go && !wake) begin
                    wfi_stall = 1'b1;
                    state_d   = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                wfi_stall = !wake;
                if (wake) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
        sleeping = (state_q == ST_SLEEP);
    end

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !wake) |=> (state_q == ST_SLEEP));

    // R7
    wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> !wfi_stall);

endmodule

// File: rtl/priv_csr_regs.sv
module priv_csr_regs
    import priv_trap_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_trap,
    input  logic [4:0]      cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic            do_mret,
    input  logic            csr_we,
    input  logic [1:0]      csr_op,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output priv_e           priv,
    output logic            tw,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] tvec_base
);

    localparam logic [XLEN-1:0] EPC_MASK  = ~XLEN'(1);
    localparam logic [XLEN-1:0] TVEC_MASK = ~XLEN'(3);

    priv_e           priv_q;
    logic            mie_q, mpie_q, tw_q;
    priv_e           mpp_q;
    logic [XLEN-1:0] epc_q, cause_q, tvec_q;
    logic [XLEN-1:0] status_rd;
    logic [XLEN-1:0] new_val;
    logic [1:0]      new_mpp;

    always_comb begin
        status_rd                       = '0;
        status_rd[BIT_MIE]              = mie_q;
        status_rd[BIT_MPIE]             = mpie_q;
        status_rd[BIT_MPP+1:BIT_MPP]    = mpp_q;
        status_rd[BIT_TW]               = tw_q;

        unique case (csr_addr)
            ADDR_STATUS: csr_rdata = status_rd;
            ADDR_TVEC:   csr_rdata = tvec_q;
            ADDR_EPC:    csr_rdata = epc_q;
            ADDR_CAUSE:  csr_rdata = cause_q;
            default:     csr_rdata = '0;
        endcase

        unique case (csr_op_e'(csr_op))
            CSROP_WRITE: new_val = csr_wdata;
            CSROP_SET:   new_val = csr_rdata | csr_wdata;
            CSROP_CLEAR: new_val = csr_rdata & ~csr_wdata;
            default:     new_val = csr_rdata;
        endcase
        new_mpp = new_val[BIT_MPP+1:BIT_MPP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            priv_q  <= PRIV_M;
            mie_q   <= 1'b0;
            mpie_q  <= 1'b0;
            mpp_q   <= PRIV_U;
            tw_q    <= 1'b0;
            epc_q   <= '0;
            cause_q <= '0;
            tvec_q  <= RESET_VEC & TVEC_MASK;
        end else if (take_trap) begin
            mpp_q   <= priv_q;
            mpie_q  <= mie_q;
            mie_q   <= 1'b0;
            priv_q  <= PRIV_M;
            epc_q   <= trap_pc & EPC_MASK;
            cause_q <= XLEN'(cause);
        end else if (do_mret) begin
            priv_q  <= mpp_q;
            mie_q   <= mpie_q;
            mpie_q  <= 1'b1;
            mpp_q   <= PRIV_U;
        end else if (csr_we) begin
            unique case (csr_addr)
                ADDR_STATUS: begin
                    mie_q  <= new_val[BIT_MIE];
                    mpie_q <= new_val[BIT_MPIE];
                    tw_q   <= new_val[BIT_TW];
                    if (new_mpp == PRIV_U || new_mpp == PRIV_M)
                        mpp_q <= priv_e'(new_mpp);
                end
                ADDR_TVEC:  tvec_q  <= new_val & TVEC_MASK;
                ADDR_EPC:   epc_q   <= new_val & EPC_MASK;
                ADDR_CAUSE: cause_q <= new_val;
                default: ;
            endcase
        end
    end

    assign priv      = priv_q;
    assign tw        = tw_q;
    assign epc       = epc_q;
    assign tvec_base = tvec_q;

    // R3
    trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (priv_q == PRIV_M && !mie_q && mpie_q == $past(mie_q)
                       && mpp_q == $past(priv_q)));

    // R4
    trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (epc_q == ($past(trap_pc) & EPC_MASK)));

    // R9
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (cause_q == XLEN'($past(cause))));

    // R8
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_mret |=> (priv_q == $past(mpp_q) && mie_q == $past(mpie_q)
                     && mpie_q && mpp_q == PRIV_U));

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
    import priv_trap_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          IRQW      = 16,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr_pc,
    input  logic            is_mret,
    input  logic            is_wfi,
    input  logic            is_ecall,
    input  logic            is_ebreak,
    input  logic            is_illegal,
    input  logic            csr_en,
    input  logic [1:0]      csr_op,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    input  logic [IRQW-1:0] irq_pending,
    input  logic [IRQW-1:0] irq_enable,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            wfi_stall,
    output logic [1:0]      priv_mode
);

    logic            take_trap, do_mret, wfi_go, csr_we, sleeping, tw;
    logic [4:0]      cause;
    priv_e           priv;
    logic [XLEN-1:0] epc, tvec_base;

    priv_trap_decide u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_valid(instr_valid),
        .sleeping   (sleeping),
        .priv       (priv),
        .tw         (tw),
        .is_mret    (is_mret),
        .is_wfi     (is_wfi),
        .is_ecall   (is_ecall),
        .is_ebreak  (is_ebreak),
        .is_illegal (is_illegal),
        .csr_en     (csr_en),
        .csr_op     (csr_op),
        .csr_addr   (csr_addr),
        .take_trap  (take_trap),
        .cause      (cause),
        .do_mret    (do_mret),
        .wfi_go     (wfi_go),
        .csr_we     (csr_we)
    );

    priv_wait_fsm #(.IRQW(IRQW)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_go     (wfi_go),
        .irq_pending(irq_pending),
        .irq_enable (irq_enable),
        .sleeping   (sleeping),
        .wfi_stall  (wfi_stall)
    );

    priv_csr_regs #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_trap (take_trap),
        .cause     (cause),
        .trap_pc   (instr_pc),
        .do_mret   (do_mret),
        .csr_we    (csr_we),
        .csr_op    (csr_op),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .priv      (priv),
        .tw        (tw),
        .epc       (epc),
        .tvec_base (tvec_base)
    );

    always_comb begin
        redirect    = take_trap || do_mret;
        redirect_pc = take_trap ? tvec_base : epc;
        priv_mode   = priv;
    end

    // R7
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> !redirect);

    // R3
    trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> (redirect_pc[1:0] == 2'b00));

endmodule

// File: tb/priv_trap_ctrl_bench.sv
module priv_trap_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_pc = '0;
    logic        is_mret = 0, is_wfi = 0, is_ecall = 0, is_ebreak = 0, is_illegal = 0;
    logic        csr_en = 0;
    logic [1:0]  csr_op = '0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [15:0] irq_pending = '0, irq_enable = '0;
    logic        redirect, wfi_stall;
    logic [31:0] redirect_pc;
    logic [1:0]  priv_mode;

    int checks = 0;
    int errors = 0;
    logic [31:0] s_rdata, s_rpc, rv;
    logic        s_redir, s_stall;

    always #2.5 clk = ~clk;

    priv_trap_ctrl u_priv_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_pc(instr_pc),
        .is_mret(is_mret), .is_wfi(is_wfi), .is_ecall(is_ecall), .is_ebreak(is_ebreak),
        .is_illegal(is_illegal), .csr_en(csr_en), .csr_op(csr_op), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_pending(irq_pending),
        .irq_enable(irq_enable), .redirect(redirect), .redirect_pc(redirect_pc),
        .wfi_stall(wfi_stall), .priv_mode(priv_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic issue(input logic [31:0] pc, input logic m, input logic w, input logic ec,
                         input logic eb, input logic il, input logic ce, input logic [1:0] op,
                         input logic [11:0] a, input logic [31:0] d);
        instr_valid = 1'b1; instr_pc = pc;
        is_mret = m; is_wfi = w; is_ecall = ec; is_ebreak = eb; is_illegal = il;
        csr_en = ce; csr_op = op; csr_addr = a; csr_wdata = d;
        #1;
        s_rdata = csr_rdata; s_redir = redirect; s_rpc = redirect_pc; s_stall = wfi_stall;
        @(posedge clk); #1;
        instr_valid = 1'b0; is_mret = 0; is_wfi = 0; is_ecall = 0; is_ebreak = 0;
        is_illegal = 0; csr_en = 0; csr_op = '0;
        @(negedge clk);
    endtask

    task automatic csr(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d);
        issue(32'h0, 0, 0, 0, 0, 0, 1, op, a, d);
    endtask

    task automatic enter_user(input logic [31:0] status, input logic [31:0] target);
        csr(2'd1, 12'h300, status);
        csr(2'd1, 12'h341, target);
        issue(32'h64, 1, 0, 0, 0, 0, 0, 2'd0, 12'h0, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 priv", {30'd0, priv_mode}, 32'd3);
        check("R1 redirect", {31'd0, redirect}, 32'd0);
        check("R1 stall", {31'd0, wfi_stall}, 32'd0);
        csr(2'd0, 12'h300, 0); check("R1 status", s_rdata, 32'h0);
        csr(2'd0, 12'h305, 0); check("R1 tvec", s_rdata, 32'h100);
        csr(2'd0, 12'h341, 0); check("R1 epc", s_rdata, 32'h0);
        csr(2'd0, 12'h342, 0); check("R1 cause", s_rdata, 32'h0);
    endtask

    task automatic t_csr_ops();
        csr(2'd1, 12'h300, 32'h0020_0000);
        csr(2'd0, 12'h300, 0); check("R5 tw readback", s_rdata, 32'h0020_0000);
        csr(2'd2, 12'h300, 32'h8);
        csr(2'd0, 12'h300, 0); check("R10 set", s_rdata, 32'h0020_0008);
        csr(2'd3, 12'h300, 32'h0020_0000);
        csr(2'd0, 12'h300, 0); check("R10 clear", s_rdata, 32'h8);
        csr(2'd1, 12'h300, 32'hFFFF_FFFF);
        csr(2'd0, 12'h300, 0); check("R10 status mask", s_rdata, 32'h0020_1888);
        csr(2'd1, 12'h300, 32'h0000_0800);
        check("R10 old value", s_rdata, 32'h0020_1888);
        csr(2'd0, 12'h300, 0); check("R10 mpp warl", s_rdata, 32'h0000_1800);
        csr(2'd1, 12'h305, 32'h203);
        csr(2'd0, 12'h305, 0); check("R10 tvec align", s_rdata, 32'h200);
        csr(2'd1, 12'h300, 32'h0);
    endtask

    task automatic t_mret_and_ecall();
        csr(2'd1, 12'h300, 32'h80);
        csr(2'd1, 12'h341, 32'h1000);
        issue(32'h50, 1, 0, 0, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R8 redirect", {31'd0, s_redir}, 32'd1);
        check("R8 target", s_rpc, 32'h1000);
        check("R8 priv user", {30'd0, priv_mode}, 32'd0);
        issue(32'h1004, 0, 0, 1, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R3 target", s_rpc, 32'h200);
        check("R3 priv machine", {30'd0, priv_mode}, 32'd3);
        csr(2'd0, 12'h342, 0); check("R9 ecall user", s_rdata, 32'd8);
        csr(2'd0, 12'h341, 0); check("R4 epc", s_rdata, 32'h1004);
        csr(2'd0, 12'h300, 0); check("R3 status from user", s_rdata, 32'h80);
        issue(32'h61, 0, 0, 0, 1, 0, 0, 2'd0, 12'h0, 0);
        csr(2'd0, 12'h342, 0); check("R9 ebreak", s_rdata, 32'd3);
        csr(2'd0, 12'h341, 0); check("R4 epc bit0", s_rdata, 32'h60);
        csr(2'd0, 12'h300, 0); check("R3 status from machine", s_rdata, 32'h1800);
    endtask

    task automatic t_umode_mret();
        enter_user(32'h0, 32'h2000);
        issue(32'h2000, 1, 0, 0, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R2 redirect to vector", s_rpc, 32'h200);
        csr(2'd0, 12'h342, 0); check("R2 cause", s_rdata, 32'd2);
        csr(2'd0, 12'h341, 0); check("R2 epc", s_rdata, 32'h2000);
        csr(2'd0, 12'h300, 0); check("R2 mpp", {30'd0, s_rdata[12:11]}, 32'd0);
    endtask

    task automatic t_wfi_user();
        irq_pending = 16'h1; irq_enable = 16'h1;
        enter_user(32'h0, 32'h3000);
        issue(32'h3000, 0, 1, 0, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R6 tw0 no redirect", {31'd0, s_redir}, 32'd0);
        check("R7 wake no stall", {31'd0, s_stall}, 32'd0);
        check("R6 still user", {30'd0, priv_mode}, 32'd0);
        issue(32'h3004, 0, 0, 1, 0, 0, 0, 2'd0, 12'h0, 0);
        enter_user(32'h0020_0000, 32'h3000);
        issue(32'h3000, 0, 1, 0, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R6 tw1 redirect", {31'd0, s_redir}, 32'd1);
        csr(2'd0, 12'h342, 0); check("R6 tw1 cause", s_rdata, 32'd2);
        csr(2'd0, 12'h341, 0); check("R6 tw1 epc", s_rdata, 32'h3000);
        csr(2'd0, 12'h300, 0); check("R5 status", s_rdata, 32'h0020_0000);
        irq_pending = '0; irq_enable = '0;
    endtask

    task automatic t_wfi_sleep();
        issue(32'h70, 0, 1, 0, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R6 machine wfi no trap", {31'd0, s_redir}, 32'd0);
        check("R7 stall entry", {31'd0, s_stall}, 32'd1);
        irq_pending = 16'h4;
        issue(32'h74, 0, 0, 1, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R7 ignored while sleeping", {31'd0, s_redir}, 32'd0);
        check("R7 pending not enabled", {31'd0, s_stall}, 32'd1);
        irq_enable = 16'h4;
        issue(32'h74, 0, 0, 1, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R7 wake releases", {31'd0, s_stall}, 32'd0);
        check("R7 wake cycle ignored", {31'd0, s_redir}, 32'd0);
        issue(32'h74, 0, 0, 1, 0, 0, 0, 2'd0, 12'h0, 0);
        check("R7 running again", {31'd0, s_redir}, 32'd1);
        csr(2'd0, 12'h342, 0); check("R9 ecall machine", s_rdata, 32'd11);
        irq_pending = '0; irq_enable = '0;
    endtask

    task automatic t_priority();
        issue(32'h80, 0, 0, 0, 1, 1, 0, 2'd0, 12'h0, 0);
        csr(2'd0, 12'h342, 0); check("R12 illegal over ebreak", s_rdata, 32'd2);
        issue(32'h84, 0, 0, 1, 0, 0, 1, 2'd1, 12'h305, 32'h400);
        check("R12 redirect old vector", s_rpc, 32'h200);
        csr(2'd0, 12'h305, 0); check("R12 write suppressed", s_rdata, 32'h200);
    endtask

    task automatic t_user_csr();
        enter_user(32'h0, 32'h4000);
        issue(32'h4000, 0, 0, 0, 0, 0, 1, 2'd1, 12'h305, 32'h800);
        check("R11 trap", {31'd0, s_redir}, 32'd1);
        csr(2'd0, 12'h342, 0); check("R11 cause", s_rdata, 32'd2);
        csr(2'd0, 12'h305, 0); check("R11 no write", s_rdata, 32'h200);
        enter_user(32'h0, 32'h4100);
        issue(32'h4100, 0, 0, 0, 0, 0, 1, 2'd0, 12'h001, 0);
        check("R11 low address no trap", {31'd0, s_redir}, 32'd0);
        check("R11 stays user", {30'd0, priv_mode}, 32'd0);
        issue(32'h4104, 0, 0, 1, 0, 0, 0, 2'd0, 12'h0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr_ops();
        t_mret_and_ecall();
        t_umode_mret();
        t_wfi_user();
        t_wfi_sleep();
        t_priority();
        t_user_csr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule